// File: doc/BRIEF.md
# Run-Length Expanding Receive FIFO

This block is a byte FIFO placed between a host bus and a parallel-port peripheral. Every entry holds a data byte and a ninth tag bit. The tag bit records which of two write addresses the host used. A write through the command address clears the tag. A write through the data address sets it.

On the read side the block can expand run-length pairs. When the direction input marks the receive direction, an entry with both its tag and data bit 7 at zero is a length byte. The block absorbs that byte internally and loads its low seven bits into a repeat counter. The entry that follows is then presented to the host one more time than the counter value. The read pointer moves past that entry only after the last copy. Host register reads and DMA read strobes consume the output in the same way.

When the direction input is 0, the FIFO returns every entry exactly as it was stored. The block only expands runs on the receive side, and a constant capability flag reports that it cannot compress transmitted data.

Top module: `rle_tag_fifo`

## Requirements
- R1: A write with `wr_sel`=1 stores the byte with tag 1. A write with `wr_sel`=0 stores it with tag 0. The tag of the entry at the head is shown on `rd_tag`.
- R2: With `dir`=0, reads return every entry, length-like ones included, unchanged and in write order, each exactly once.
- R3: With `dir`=1, an entry with tag 0 and bit 7 = 0 is never shown on `rd_data`. Its bits 6:0 give the count N. The next entry is shown for N+1 reads before the FIFO moves past it.
- R4: N = 0 returns the data byte once. N = 127 returns it 128 times.
- R5: With `dir`=1, an entry with tag 0 and bit 7 = 1, or any entry with tag 1, is returned once and unchanged.
- R6: `empty` stays low while a run is being replayed, even if the replayed entry is the only one stored. It rises after the final copy is read. A stored length byte with no data after it yet keeps `empty` high.
- R7: `full` is high when 2^AW entries are stored. A write while full is dropped and leaves the stored data intact.
- R8: A read strobe while `empty` is high has no effect.
- R9: `rle_tx_cap` reads 0.
- R10: `dma_rd` consumes output, including replayed copies, exactly like `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir | input | 1 | 1 = receive direction, which enables expansion |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 = command/length address (tag 0), 1 = data address (tag 1) |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Host register read strobe |
| dma_rd | input | 1 | DMA read strobe |
| rd_data | output | 8 | Byte currently offered to the reader |
| rd_tag | output | 1 | Tag of the offered entry |
| empty | output | 1 | No byte available to read |
| full | output | 1 | Storage full |
| rle_tx_cap | output | 1 | Compression capability flag, always 0 |

## Verification
The bench builds the block with AW=3, which gives eight entries. At that size, filling the FIFO and dropping a write while it is full each take only a few cycles. The counter is seven bits wide whatever the depth, so the bench can still drive the longest run of 128 copies through the DMA strobe and the shortest run of one copy. The bench also covers a length byte left waiting with no data behind it, and reads issued while the FIFO is empty.

// File: rtl/rle_tag_fifo.sv
module rle_tag_fifo #(
  parameter int AW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       dma_rd,
  output logic [7:0] rd_data,
  output logic       rd_tag,
  output logic       empty,
  output logic       full,
  output logic       rle_tx_cap
);
  localparam int DEPTH = 1 << AW;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          run;
  logic [6:0]    rpt;

  wire [8:0] head     = mem[rp];
  wire       head_len = !head[8] && !head[7];
  wire       absorb   = dir && !run && (cnt != 0) && head_len;
  wire       take     = (rd_en || dma_rd) && !empty;
  wire       hold     = take && dir && run && (rpt != 0);
  wire       pop      = absorb || (take && !hold);
  wire       push     = wr_en && !full;

  assign empty      = (cnt == 0) || (dir && !run && head_len);
  assign full       = cnt == (AW+1)'(DEPTH);
  assign rd_data    = head[7:0];
  assign rd_tag     = head[8];
  assign rle_tx_cap = 1'b0;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_sel, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      rpt <= '0;
    end else if (!dir) begin
      run <= 1'b0;
    end else if (absorb) begin
      run <= 1'b1;
      rpt <= head[6:0];
    end else if (take && run) begin
      if (rpt == 0) run <= 1'b0;
      else          rpt <= rpt - 1'b1;
    end
  end
endmodule

// File: rtl/rle_tag_fifo_chk.sv
module rle_tag_fifo_chk #(
  parameter int AW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir,
  input logic       wr_en,
  input logic       rd_en,
  input logic       dma_rd,
  input logic [7:0] rd_data,
  input logic       empty,
  input logic       full,
  input logic [AW:0] cnt,
  input logic       run,
  input logic [6:0] rpt
);
  localparam int DEPTH = 1 << AW;

  // R7
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (AW+1)'(DEPTH) && wr_en && !rd_en && !dma_rd && !dir)
      |=> cnt == (AW+1)'(DEPTH));

  // R3
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && run && rpt != 0 && (rd_en || dma_rd))
      |=> rd_data == $past(rd_data));

  // R6
  replay_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != 0) |-> !empty);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 0 && (rd_en || dma_rd) && !wr_en) |=> cnt == 0);

  // R4
  run_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && run && rpt == 0 && (rd_en || dma_rd)) |=> !run);
endmodule

bind rle_tag_fifo rle_tag_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .wr_en(wr_en), .rd_en(rd_en),
  .dma_rd(dma_rd), .rd_data(rd_data), .empty(empty), .full(full),
  .cnt(cnt), .run(run), .rpt(rpt)
);

// File: tb/tb_rle_tag_fifo.sv
module tb_rle_tag_fifo;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, dir = 0, wr_en = 0, wr_sel = 0, rd_en = 0, dma_rd = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_tag, empty, full, rle_tx_cap;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  rle_tag_fifo #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .dir(dir), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .dma_rd(dma_rd), .rd_data(rd_data),
    .rd_tag(rd_tag), .empty(empty), .full(full), .rle_tx_cap(rle_tx_cap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] d, input bit tag, input bit use_dma, input string req);
    @(negedge clk);
    chk(!empty, {req, " not empty"}, empty, 0);
    chk(rd_data == d && rd_tag == tag, req, {rd_tag, rd_data}, {tag, d});
    if (use_dma) dma_rd = 1; else rd_en = 1;
    @(negedge clk); dma_rd = 0; rd_en = 0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(empty, req, empty, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(empty && !full, "R7 reset flags", {empty, full}, 2'b10);
    chk(rle_tx_cap == 0, "R9 tx cap", rle_tx_cap, 0);
  endtask

  task automatic t_raw;
    dir = 0;
    wr(0, 8'h05); wr(1, 8'hA5); wr(0, 8'h83);
    rd(8'h05, 0, 0, "R1 R2 cmd raw");
    rd(8'hA5, 1, 0, "R1 R2 data raw");
    rd(8'h83, 0, 0, "R2 raw");
    expect_empty("R2 drained");
  endtask

  task automatic t_run(input int n, input logic [7:0] d, input bit use_dma);
    dir = 1;
    wr(0, 8'(n)); wr(1, d);
    for (int i = 0; i <= n; i++) rd(d, 1, use_dma, use_dma ? "R10 R4 R3 dma copy" : "R3 R4 R6 copy");
    expect_empty("R6 empty after run");
  endtask

  task automatic t_notlen;
    dir = 1;
    wr(0, 8'h85); wr(1, 8'h11); wr(1, 8'h22);
    rd(8'h85, 0, 0, "R5 tag0 bit7 set");
    rd(8'h11, 1, 0, "R5 data");
    rd(8'h22, 1, 1, "R5 data bit7 clear");
    expect_empty("R5 drained");
  endtask

  task automatic t_empty_rd;
    dir = 0;
    @(negedge clk); rd_en = 1; dma_rd = 1;
    @(negedge clk); rd_en = 0; dma_rd = 0;
    chk(empty, "R8 still empty", empty, 1);
    wr(1, 8'h5A);
    rd(8'h5A, 1, 0, "R8 after empty read");
    expect_empty("R8 drained");
  endtask

  task automatic t_full;
    dir = 0;
    for (int i = 0; i < DEPTH; i++) wr(1, 8'(i + 8'h40));
    @(negedge clk); chk(full, "R7 full", full, 1);
    wr(1, 8'hFF);
    for (int i = 0; i < DEPTH; i++) rd(8'(i + 8'h40), 1, 0, "R7 content kept");
    expect_empty("R7 drained");
  endtask

  task automatic t_pending;
    dir = 1;
    wr(0, 8'h02);
    expect_empty("R6 lone length empty");
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    wr(1, 8'h3C);
    for (int i = 0; i < 3; i++) rd(8'h3C, 1, 0, "R3 R6 late data");
    expect_empty("R6 pending drained");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_raw();
    t_run(3, 8'h6E, 0);
    t_run(0, 8'hC3, 0);
    t_run(127, 8'h17, 1);
    t_notlen();
    t_empty_rd();
    t_full();
    t_pending();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule